// File: doc/BRIEF.md
# Auto-Reload Decrementer

This block is a down-counter that software loads through a small register port and that steps once per time-base tick. When the count steps from one to zero, the block records an expiry in a sticky status flag. The flag can raise an interrupt line if the interrupt enable is set. If auto-reload is enabled and the reload register holds a nonzero value, the expiry step puts the reload value into the counter instead of zero, and counting goes on periodically. Otherwise the counter stops at zero.

Software reaches four registers through one write port and one combinational read port. The count is at address 0 and the reload value at address 1. Address 2 holds the control bits, at positions that the surrounding software decodes: bit 26 is the interrupt enable and bit 22 is auto-reload. Address 3 is status: bit 27 is the expiry flag, and software clears it by writing a one to that bit. The time base itself is not part of the block. It is supplied as a one-cycle tick enable.

Top module: `auto_reload_decrementer`

## Requirements
- R1: After a synchronous active-low reset, the count, reload value, control bits and status flag all read as zero, and `irq` is 0.
- R2: In a cycle with `tick_en` high, no count write and a count above one, the count drops by exactly one. Without `tick_en` the count holds.
- R3: A write to address 0 loads the count on the next edge. It overrides any decrement or reload in that cycle, and it suppresses any expiry in that cycle.
- R4: A tick while the count is one, with no count write, is an expiry. The status flag (address 3, bit 27) is set, and without a reload the count becomes zero.
- R5: When auto-reload (address 2, bit 22) is 1 and the reload register is nonzero, an expiry loads the count with the reload value held before that edge.
- R6: When auto-reload is 1 but the reload register is zero, an expiry leaves the count at zero and no reload takes place.
- R7: At a count of zero, ticks change neither the count nor the status flag. Writing zero to the count is never an expiry.
- R8: Writing address 3 with bit 27 set clears the status flag, and writes to other bits of that address have no effect. If an expiry and a clear fall in the same cycle, the flag ends up set.
- R9: `irq` is 1 exactly while the status flag and the interrupt enable (address 2, bit 26) are both 1.
- R10: A write to address 1 stores the whole reload value. Reads of address 2 show only bits 26 and 22, and reads of address 3 show only bit 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Time-base tick, one cycle per decrement |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register written (0 count, 1 reload, 2 control, 3 status) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Register read, same map as writes |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Decrementer interrupt request |

## Verification
The bench drives the ties that are easy to get wrong. One is a count write on the very tick that would expire: a design that let the decrement win would load the wrong value and raise a stray status flag. Another is a status clear in the same cycle as an expiry: a design where the clear won would drop an event. The bench also runs auto-reload with a zero reload register and ticks at a count of zero, which catch a design that reloads zero into a running counter or wraps to all ones and expires again. Partial writes to the status address catch a clear that ignores the bit position.

// File: rtl/dectmr_pkg.sv
// Shared definitions for the auto-reload decrementer: register selects and
// the control/status bit positions that software decodes.
package dectmr_pkg;

    localparam int SEL_W   = 2;
    localparam int IE_BIT  = 26;  // interrupt enable in the control word
    localparam int ARE_BIT = 22;  // auto-reload enable in the control word
    localparam int ST_BIT  = 27;  // expiry flag in the status word

    typedef enum logic [SEL_W-1:0] {
        SEL_COUNT  = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic irq_en;
        logic reload_en;
    } ctrl_t;

endpackage

// File: rtl/dectmr_regfile.sv
// Register file: decodes writes into reload/control storage and strobes
// for the counter and status flag, and muxes the read data.
// Assumes DATA_W is wide enough to hold bit ST_BIT.
module dectmr_regfile
    import dectmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic              status_q,
    output logic [DATA_W-1:0] reload_q,
    output ctrl_t             ctrl_q,
    output logic              cnt_wr,
    output logic              status_clr,
    output logic [DATA_W-1:0] rd_data
);

    reg_sel_e wsel;
    reg_sel_e rsel;
    logic     reload_wr;
    logic     ctrl_wr;

    assign wsel = reg_sel_e'(wr_addr);
    assign rsel = reg_sel_e'(rd_addr);

    // Turn one write into a per-register strobe.
    always_comb begin
        cnt_wr     = 1'b0;
        reload_wr  = 1'b0;
        ctrl_wr    = 1'b0;
        status_clr = 1'b0;
        if (wr_en) begin
            case (wsel)
                SEL_COUNT:  cnt_wr     = 1'b1;
                SEL_RELOAD: reload_wr  = 1'b1;
                SEL_CTRL:   ctrl_wr    = 1'b1;
                SEL_STATUS: status_clr = wr_data[ST_BIT];
                default:    ;
            endcase
        end
    end

    // Hold the reload value and the two control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '0;
        end else begin
            if (reload_wr) reload_q <= wr_data;
            if (ctrl_wr) begin
                ctrl_q.irq_en    <= wr_data[IE_BIT];
                ctrl_q.reload_en <= wr_data[ARE_BIT];
            end
        end
    end

    // Read mux; unused bit positions read as zero.
    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_COUNT:  rd_data = cnt_q;
            SEL_RELOAD: rd_data = reload_q;
            SEL_CTRL: begin
                rd_data[IE_BIT]  = ctrl_q.irq_en;
                rd_data[ARE_BIT] = ctrl_q.reload_en;
            end
            SEL_STATUS: rd_data[ST_BIT] = status_q;
            default:    rd_data = '0;
        endcase
    end

    // Reload register keeps its value when not written.
    p_reload_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_wr |=> reload_q == $past(reload_q));

endmodule

// File: rtl/dectmr_counter.sv
// Down-counter: steps on each tick while nonzero, flags expiry on the step
// from one, and then either reloads or stops at zero. A software write
// overrides everything in its cycle.
module dectmr_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] reload_q,
    input  logic              reload_en,
    output logic [DATA_W-1:0] cnt_q,
    output logic              expire
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic              at_last;
    logic              reload_ok;
    logic [DATA_W-1:0] cnt_d;

    assign at_last   = (cnt_q == ONE);
    assign reload_ok = reload_en && (reload_q != '0);
    assign expire    = tick_en && at_last && !cnt_wr;

    // Next count: write beats tick; expiry picks reload or zero.
    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr) begin
            cnt_d = wr_data;
        end else if (tick_en && (cnt_q != '0)) begin
            if (at_last) cnt_d = reload_ok ? reload_q : '0;
            else         cnt_d = cnt_q - ONE;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(wr_data));

    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_wr && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);

    p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && cnt_q == '0) |=> cnt_q == '0);

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload_en && reload_q != '0) |=> cnt_q == $past(reload_q));

    p_zero_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload_q == '0) |=> cnt_q == '0);

endmodule

// File: rtl/dectmr_status.sv
// Sticky expiry flag with write-one-to-clear, and the gated interrupt.
// Assumes expire and status_clr are single-cycle strobes.
module dectmr_status (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic status_clr,
    input  logic irq_en,
    output logic status_q,
    output logic irq
);

    // Flag register: a new expiry outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          status_q <= 1'b0;
        else if (expire)     status_q <= 1'b1;
        else if (status_clr) status_q <= 1'b0;
    end

    // Interrupt follows the flag while enabled.
    assign irq = status_q && irq_en;

    p_set_on_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status_q);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !status_clr) |=> status_q);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !expire) |=> !status_q);

    p_no_spurious_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_q && !expire) |=> !status_q);

endmodule

// File: rtl/auto_reload_decrementer.sv
// Top of the auto-reload decrementer: joins the register file, the counter
// and the status flag. Assumes tick_en is a clean one-cycle time-base tick.
module auto_reload_decrementer
    import dectmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] reload_q;
    ctrl_t             ctrl_q;
    logic              cnt_wr;
    logic              status_clr;
    logic              status_q;
    logic              expire;

    dectmr_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .cnt_q      (cnt_q),
        .status_q   (status_q),
        .reload_q   (reload_q),
        .ctrl_q     (ctrl_q),
        .cnt_wr     (cnt_wr),
        .status_clr (status_clr),
        .rd_data    (rd_data)
    );

    dectmr_counter #(.DATA_W(DATA_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cnt_wr    (cnt_wr),
        .wr_data   (wr_data),
        .reload_q  (reload_q),
        .reload_en (ctrl_q.reload_en),
        .cnt_q     (cnt_q),
        .expire    (expire)
    );

    dectmr_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .status_clr (status_clr),
        .irq_en     (ctrl_q.irq_en),
        .status_q   (status_q),
        .irq        (irq)
    );

    // An interrupt only follows a recorded expiry (R9).
    p_irq_after_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> status_q && ctrl_q.irq_en);

endmodule

// File: tb/tb_auto_reload_decrementer.sv
// Bench: a behavioural model steps alongside the design and is compared
// on every cycle, plus fixed-value spot checks.
module tb_auto_reload_decrementer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // model state
    logic [31:0] m_cnt = '0, m_rel = '0;
    logic        m_ie = 1'b0, m_are = 1'b0, m_st = 1'b0;

    always #5 clk = ~clk;

    auto_reload_decrementer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    // Behavioural model of the register-level behaviour.
    always @(posedge clk) begin
        logic wc, exp_now;
        cycles++;
        if (!rst_n) begin
            m_cnt = '0; m_rel = '0; m_ie = 0; m_are = 0; m_st = 0;
        end else begin
            wc = wr_en && wr_addr == 2'd0;
            exp_now = !wc && tick_en && m_cnt == 32'd1;
            if (exp_now) m_st = 1;
            else if (wr_en && wr_addr == 2'd3 && wr_data[27]) m_st = 0;
            if (wc) m_cnt = wr_data;
            else if (tick_en && m_cnt != 0)
                m_cnt = (m_cnt == 1) ? ((m_are && m_rel != 0) ? m_rel : 0) : m_cnt - 1;
            if (wr_en && wr_addr == 2'd1) m_rel = wr_data;
            if (wr_en && wr_addr == 2'd2) begin
                m_ie = wr_data[26]; m_are = wr_data[22];
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_rel;
            2'd2: return (32'(m_ie) << 26) | (32'(m_are) << 22);
            default: return 32'(m_st) << 27;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare();
        if (rst_n) begin
            check(cur_req, rd_data, m_read(rd_addr));
            check(cur_req, {31'b0, irq}, {31'b0, m_st && m_ie});
        end
    endtask

    // One cycle of stimulus, after comparing the previous edge's result.
    task automatic step(input logic t, input logic w, input logic [1:0] a,
                        input logic [31:0] d);
        @(negedge clk);
        compare();
        tick_en = t; wr_en = w; wr_addr = a; wr_data = d; rd_addr = 2'd0;
    endtask

    // Idle cycle with a fixed-value read check.
    task automatic peek(input logic [1:0] ra, input logic [31:0] exp, input string req);
        @(negedge clk);
        compare();
        tick_en = 0; wr_en = 0; rd_addr = ra;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic irq_is(input logic exp, input string req);
        @(negedge clk);
        compare();
        tick_en = 0; wr_en = 0;
        check(req, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        peek(2'd0, 32'h0, "R1"); peek(2'd1, 32'h0, "R1");
        peek(2'd2, 32'h0, "R1"); peek(2'd3, 32'h0, "R1");
        irq_is(1'b0, "R1");
        // R3 count write
        cur_req = "R3";
        step(0, 1, 2'd0, 32'd5);
        peek(2'd0, 32'd5, "R3");
        // R2 decrement only on ticks
        cur_req = "R2";
        step(1, 0, 0, 0); step(0, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0);
        peek(2'd0, 32'd2, "R2");
        // R4 expiry to zero
        cur_req = "R4";
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        peek(2'd3, 32'h0800_0000, "R4");
        peek(2'd0, 32'd0, "R4");
        irq_is(1'b0, "R9");
        // R9 enable gates irq
        cur_req = "R9";
        step(0, 1, 2'd2, 32'h0400_0000);
        irq_is(1'b1, "R9");
        // R7 ticks at zero
        cur_req = "R7";
        repeat (4) step(1, 0, 0, 0);
        peek(2'd0, 32'd0, "R7");
        // R8 partial writes ignored, then clear
        cur_req = "R8";
        step(0, 1, 2'd3, 32'h0);
        step(0, 1, 2'd3, 32'hF7FF_FFFF);
        peek(2'd3, 32'h0800_0000, "R8");
        step(0, 1, 2'd3, 32'h0800_0000);
        peek(2'd3, 32'h0, "R8");
        irq_is(1'b0, "R9");
        cur_req = "R7";
        step(0, 1, 2'd0, 32'd0);
        repeat (3) step(1, 0, 0, 0);
        peek(2'd3, 32'h0, "R7");
        // R5 periodic reload
        cur_req = "R5";
        step(0, 1, 2'd1, 32'd3);
        step(0, 1, 2'd2, 32'h0440_0000);
        step(0, 1, 2'd0, 32'd2);
        repeat (2) step(1, 0, 0, 0);
        peek(2'd0, 32'd3, "R5");
        repeat (9) step(1, 0, 0, 0);
        peek(2'd3, 32'h0800_0000, "R5");
        // R8 set wins over clear in the same cycle
        cur_req = "R8";
        step(0, 1, 2'd3, 32'h0800_0000);
        step(0, 1, 2'd0, 32'd1);
        step(1, 1, 2'd3, 32'h0800_0000);
        peek(2'd3, 32'h0800_0000, "R8");
        // R3 count write wins at the expiry tick
        cur_req = "R3";
        step(0, 1, 2'd3, 32'h0800_0000);
        step(0, 1, 2'd0, 32'd1);
        step(1, 1, 2'd0, 32'd7);
        peek(2'd0, 32'd7, "R3");
        peek(2'd3, 32'h0, "R3");
        // R6 auto-reload with zero reload value
        cur_req = "R6";
        step(0, 1, 2'd1, 32'd0);
        step(0, 1, 2'd0, 32'd2);
        repeat (5) step(1, 0, 0, 0);
        peek(2'd0, 32'd0, "R6");
        peek(2'd3, 32'h0800_0000, "R6");
        // R10 readback
        cur_req = "R10";
        step(0, 1, 2'd1, 32'hA5A5_1234);
        peek(2'd1, 32'hA5A5_1234, "R10");
        step(0, 1, 2'd2, 32'hFFFF_FFFF);
        peek(2'd2, 32'h0440_0000, "R10");
        step(0, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        wait (cycles > 5000);
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d cycles expected fewer than 5000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule